// File: doc/BRIEF.md
# Dual-Sensor Thermal Alarm and Status Logic

This block turns each completed temperature measurement into alarm decisions. A local reading in whole degrees and a remote reading in quarter degrees arrive together with a one-cycle completion strobe. The remote reading is first corrected by a signed calibration offset. Both readings are then compared against programmable high, low and trip limits. The results are held in an 8-bit status word and drive two active-low pins.

The first pin, `therm_n`, is a self-clearing trip output with a shared hysteresis. The second pin, `alert_n`, normally carries a latched, host-cleared alarm. Before it asserts, a programmable number of successive faulty readings is required. A mode input turns this second pin into a second trip output instead. That output runs off the high limits with the same hysteresis, and it needs no host action to release.

Register storage, the conversion engine and the serial bus sit outside this block. The block only sees the register values as plain inputs, plus a strobe telling it that the status word was read and a strobe telling it that an alert response was served.

Top module: `thermal_alarm`

## Requirements
- R1: After reset, `status_o` is 00h and both `alert_n` and `therm_n` are high.
- R2: Status bit 7 shows `busy_in` as it was sampled on the previous clock edge.
- R3: Limit comparisons take place only in a cycle where `meas_done` is high. Changing a limit input has no effect on `status_o` or on either pin until the next measurement.
- R4: Local fault bits: bit 6 is set when the local reading is strictly greater than `loc_hi_lim`. Bit 5 is set when the local reading is less than or equal to `loc_lo_lim`.
- R5: The corrected remote value is {`rem_rd_int`,`rem_rd_frac`} plus `rem_ofs`, taken as 10-bit two's complement in quarter degrees, clamped to 0..1023. Bit 4 is set when the corrected value is greater than {`rem_hi_int`,`rem_hi_frac`}. Bit 3 is set when it is less than or equal to {`rem_lo_int`,`rem_lo_frac`}.
- R6: Bit 2 is set when `diode_open` is high at a measurement.
- R7: Bits 6..2 are sticky. A measurement can only set them. A `status_rd` pulse clears each bit whose condition was absent at the most recent measurement.
- R8: Bit 0 (local) and bit 1 (remote) are trip states. Each one sets when its reading is greater than its trip limit. Each one clears when the reading plus `trip_hyst` is less than the trip limit. `therm_n` is low whenever either bit is set.
- R9: The number of consecutive faulty readings needed is one plus the number of ones in `fault_code`, which is meant to be 000, 001, 011 or 111 for 1 to 4. A reading counts as faulty if any condition of bits 6..2 holds. A reading with none of them resets the count.
- R10: When the required count is reached, the alert latch sets. It clears on `alert_ack` only if bits 6..2 are all zero. In alert mode (`pin_mode`=0), `alert_n` is low while the latch is set and `alert_mask` is 0.
- R11: With `pin_mode`=1, `alert_n` is a second trip output driven by the high limits. It sets when either reading is greater than its high limit. The local state clears when local plus `trip_hyst` is below `loc_hi_lim`. The remote state clears when the corrected remote value plus four times `trip_hyst` is below the remote high limit. `alert_mask` and `alert_ack` have no effect on it.
- R12: `status_o`, `alert_n` and `therm_n` change on the clock edge that samples `meas_done`, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_done | input | 1 | One-cycle strobe: a new reading pair is valid |
| busy_in | input | 1 | Converter busy indication |
| diode_open | input | 1 | Remote diode open-circuit flag |
| loc_rd | input | 8 | Local reading, whole degrees |
| rem_rd_int | input | 8 | Remote reading, integer part |
| rem_rd_frac | input | 2 | Remote reading, quarter-degree part |
| rem_ofs | input | 10 | Remote offset, two's complement quarter degrees |
| loc_hi_lim | input | 8 | Local high limit |
| loc_lo_lim | input | 8 | Local low limit |
| loc_trip_lim | input | 8 | Local trip limit |
| rem_hi_int | input | 8 | Remote high limit, integer part |
| rem_hi_frac | input | 2 | Remote high limit, quarter part |
| rem_lo_int | input | 8 | Remote low limit, integer part |
| rem_lo_frac | input | 2 | Remote low limit, quarter part |
| rem_trip_lim | input | 8 | Remote trip limit, whole degrees |
| trip_hyst | input | 7 | Shared trip hysteresis, whole degrees |
| alert_mask | input | 1 | Masks `alert_n` in alert mode |
| pin_mode | input | 1 | 0: latched alert pin, 1: second trip pin |
| fault_code | input | 3 | Consecutive-fault requirement code |
| status_rd | input | 1 | Strobe: status word was read |
| alert_ack | input | 1 | Strobe: alert response was served |
| status_o | output | 8 | Status word |
| alert_n | output | 1 | Active-low alert / second trip pin |
| therm_n | output | 1 | Active-low trip pin |

## Verification
The local reading is swept across its full range with fixed limits. This separates the strict-greater high compare from the inclusive low compare. It also exercises the trip hysteresis as the value rises and then wraps. The remote sweep covers every integer and fractional value under zero, positive, negative and extreme offsets. This exposes errors in the fraction bits, in the sign extension and in the clamping at both ends.

Separate patterns check the following:
- runs of faults broken by one clean reading, under each count code;
- read-to-clear with the condition still present versus removed;
- acknowledges given while bits are still set;
- mask and mode changes;
- a limit change with no measurement.

These patterns separate the latching path from the self-clearing paths.

// File: rtl/therm_alarm_pkg.sv
package therm_alarm_pkg;
  // status word bit positions
  localparam int unsigned ST_LOC_TRIP = 0;
  localparam int unsigned ST_REM_TRIP = 1;
  localparam int unsigned ST_BUSY     = 7;
  localparam int unsigned ST_FLT_LSB  = 2;
  localparam int unsigned N_FLT       = 5;

  // sticky fault flags, packed so that they map onto status bits 6..2
  typedef struct packed {
    logic loc_high;
    logic loc_low;
    logic rem_high;
    logic rem_low;
    logic rem_open;
  } fault_vec_t;

  typedef enum logic {PIN_ALERT = 1'b0, PIN_TRIP2 = 1'b1} pin_mode_e;
endpackage

// File: rtl/remote_corrector.sv
module remote_corrector #(
  parameter int RW = 10
) (
  input  logic [RW-1:0] raw,
  input  logic [RW-1:0] ofs,
  output logic [RW-1:0] corr
);
  logic signed [RW+1:0] sum;

  assign sum = $signed({2'b00, raw}) + $signed({{2{ofs[RW-1]}}, ofs});

  always_comb begin
    if (sum[RW+1])      corr = '0;          // below zero
    else if (sum[RW])   corr = '1;          // above full scale
    else                corr = sum[RW-1:0];
  end
endmodule

// File: rtl/hyst_tracker.sv
module hyst_tracker #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic [W-1:0] val,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] hys,
  output logic         state_q,
  output logic         state_nxt
);
  logic below_band;

  assign below_band = ({1'b0, val} + {1'b0, hys}) < {1'b0, lim};

  always_comb begin
    state_nxt = state_q;
    if (sample) begin
      if (val > lim)       state_nxt = 1'b1;
      else if (below_band) state_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= 1'b0;
    else     state_q <= state_nxt;
  end
endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
  parameter int MAXC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample,
  input  logic            any_fault,
  input  logic [MAXC-2:0] code,
  output logic            fire
);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;
  logic [CW:0]   inc;

  always_comb begin
    need = CW'(1);
    for (int i = 0; i < MAXC - 1; i++) need = need + CW'(code[i]);
  end

  assign inc  = {1'b0, cnt_q} + (CW+1)'(1);
  assign fire = sample & any_fault & (inc >= {1'b0, need});

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (sample) begin
      if (!any_fault) cnt_q <= '0;
      else if (fire)  cnt_q <= need;
      else            cnt_q <= inc[CW-1:0];
    end
  end
endmodule

// File: rtl/thermal_alarm.sv
module thermal_alarm
  import therm_alarm_pkg::*;
#(
  parameter int LW   = 8,
  parameter int FW   = 2,
  parameter int HW   = 7,
  parameter int MAXC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_done,
  input  logic          busy_in,
  input  logic          diode_open,
  input  logic [LW-1:0] loc_rd,
  input  logic [LW-1:0] rem_rd_int,
  input  logic [FW-1:0] rem_rd_frac,
  input  logic [LW+FW-1:0] rem_ofs,
  input  logic [LW-1:0] loc_hi_lim,
  input  logic [LW-1:0] loc_lo_lim,
  input  logic [LW-1:0] loc_trip_lim,
  input  logic [LW-1:0] rem_hi_int,
  input  logic [FW-1:0] rem_hi_frac,
  input  logic [LW-1:0] rem_lo_int,
  input  logic [FW-1:0] rem_lo_frac,
  input  logic [LW-1:0] rem_trip_lim,
  input  logic [HW-1:0] trip_hyst,
  input  logic          alert_mask,
  input  logic          pin_mode,
  input  logic [MAXC-2:0] fault_code,
  input  logic          status_rd,
  input  logic          alert_ack,
  output logic [7:0]    status_o,
  output logic          alert_n,
  output logic          therm_n
);
  localparam int RW   = LW + FW;
  localparam int NTRK = 4;            // 0 loc trip, 1 rem trip, 2 loc high, 3 rem high
  localparam int HPAD = RW - HW - FW; // LW must exceed HW

  logic [RW-1:0] rem_corr;
  logic [RW-1:0] loc_q, hys_q, rem_hi_q, rem_lo_q;
  logic [RW-1:0] trk_val [NTRK];
  logic [RW-1:0] trk_lim [NTRK];
  logic [NTRK-1:0] trk_q, trk_nxt;

  fault_vec_t cond_now, cond_q, sticky_q;
  logic       busy_q;
  logic       fire, latch_q, latch_d;
  logic       alert_pin_d;

  remote_corrector #(.RW(RW)) u_corr (
    .raw  ({rem_rd_int, rem_rd_frac}),
    .ofs  (rem_ofs),
    .corr (rem_corr)
  );

  // all compares share one quarter-degree domain
  assign loc_q    = {loc_rd, {FW{1'b0}}};
  assign hys_q    = {{HPAD{1'b0}}, trip_hyst, {FW{1'b0}}};
  assign rem_hi_q = {rem_hi_int, rem_hi_frac};
  assign rem_lo_q = {rem_lo_int, rem_lo_frac};

  assign trk_val[0] = loc_q;
  assign trk_lim[0] = {loc_trip_lim, {FW{1'b0}}};
  assign trk_val[1] = rem_corr;
  assign trk_lim[1] = {rem_trip_lim, {FW{1'b0}}};
  assign trk_val[2] = loc_q;
  assign trk_lim[2] = {loc_hi_lim, {FW{1'b0}}};
  assign trk_val[3] = rem_corr;
  assign trk_lim[3] = rem_hi_q;

  for (genvar g = 0; g < NTRK; g++) begin : g_trk
    hyst_tracker #(.W(RW)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .sample    (meas_done),
      .val       (trk_val[g]),
      .lim       (trk_lim[g]),
      .hys       (hys_q),
      .state_q   (trk_q[g]),
      .state_nxt (trk_nxt[g])
    );
  end

  // alert-side conditions of the current reading pair
  always_comb begin
    cond_now.loc_high = loc_rd > loc_hi_lim;
    cond_now.loc_low  = loc_rd <= loc_lo_lim;
    cond_now.rem_high = rem_corr > rem_hi_q;
    cond_now.rem_low  = rem_corr <= rem_lo_q;
    cond_now.rem_open = diode_open;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      cond_q   <= '0;
      busy_q   <= 1'b0;
    end else begin
      busy_q <= busy_in;
      if (meas_done) begin
        sticky_q <= sticky_q | cond_now;
        cond_q   <= cond_now;
      end else if (status_rd) begin
        sticky_q <= sticky_q & cond_q;
      end
    end
  end

  fault_qualifier #(.MAXC(MAXC)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .sample    (meas_done),
    .any_fault (|cond_now),
    .code      (fault_code),
    .fire      (fire)
  );

  always_comb begin
    latch_d = latch_q;
    if (fire)                            latch_d = 1'b1;
    else if (alert_ack && sticky_q == '0) latch_d = 1'b0;
  end

  always_comb begin
    if (pin_mode_e'(pin_mode) == PIN_TRIP2) alert_pin_d = ~(trk_nxt[2] | trk_nxt[3]);
    else                                    alert_pin_d = ~(latch_d & ~alert_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      alert_n <= 1'b1;
      therm_n <= 1'b1;
    end else begin
      latch_q <= latch_d;
      alert_n <= alert_pin_d;
      therm_n <= ~(trk_nxt[0] | trk_nxt[1]);
    end
  end

  always_comb begin
    status_o = '0;
    status_o[ST_LOC_TRIP] = trk_q[0];
    status_o[ST_REM_TRIP] = trk_q[1];
    status_o[ST_FLT_LSB +: N_FLT] = sticky_q;
    status_o[ST_BUSY] = busy_q;
  end
endmodule

// File: rtl/thermal_alarm_chk.sv
module thermal_alarm_chk (
  input logic       clk,
  input logic       rst,
  input logic       meas_done,
  input logic       status_rd,
  input logic       alert_ack,
  input logic       busy_in,
  input logic       alert_mask,
  input logic       pin_mode,
  input logic [7:0] status_o,
  input logic       alert_n,
  input logic       therm_n,
  input logic       latch
);
  a_r2_busy_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_o[7] == $past(busy_in));

  a_r3_trip_only_on_meas: assert property (@(posedge clk) disable iff (rst)
    !meas_done |=> $stable(status_o[1:0]) && $stable(therm_n));

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !status_rd |=> ((status_o[6:2] & $past(status_o[6:2])) == $past(status_o[6:2])));

  a_r7_read_never_sets: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !meas_done) |=> ((status_o[6:2] & ~$past(status_o[6:2])) == 5'b0));

  a_r8_therm_pin: assert property (@(posedge clk) disable iff (rst)
    therm_n == !(status_o[0] || status_o[1]));

  a_r10_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (latch && !alert_ack) |=> latch);

  a_r10_release_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (latch && (|status_o[6:2])) |=> latch);

  a_r10_mask_hides: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pin_mode) && $past(alert_mask)) |-> alert_n);
endmodule

bind thermal_alarm thermal_alarm_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .meas_done  (meas_done),
  .status_rd  (status_rd),
  .alert_ack  (alert_ack),
  .busy_in    (busy_in),
  .alert_mask (alert_mask),
  .pin_mode   (pin_mode),
  .status_o   (status_o),
  .alert_n    (alert_n),
  .therm_n    (therm_n),
  .latch      (latch_q)
);

// File: tb/thermal_alarm_bench.sv
module thermal_alarm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       meas_done = 0, busy_in = 0, diode_open = 0;
  logic [7:0] loc_rd = 0, rem_rd_int = 0;
  logic [1:0] rem_rd_frac = 0;
  logic [9:0] rem_ofs = 0;
  logic [7:0] loc_hi_lim = 0, loc_lo_lim = 0, loc_trip_lim = 0;
  logic [7:0] rem_hi_int = 0, rem_lo_int = 0, rem_trip_lim = 0;
  logic [1:0] rem_hi_frac = 0, rem_lo_frac = 0;
  logic [6:0] trip_hyst = 0;
  logic       alert_mask = 0, pin_mode = 0;
  logic [2:0] fault_code = 0;
  logic       status_rd = 0, alert_ack = 0;
  logic [7:0] status_o;
  logic       alert_n, therm_n;

  thermal_alarm u_thermal_alarm (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [4:0] m_sticky = 0, m_cond = 0;
  logic       m_tl = 0, m_tr = 0, m_t2l = 0, m_t2r = 0, m_latch = 0, m_busy = 0;
  int         m_cnt = 0;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_busy, m_sticky, m_tr, m_tl};
  endfunction

  task automatic check_all(input string tag);
    check(status_o, exp_status(), "status", tag);
    check(alert_n, pin_mode ? !(m_t2l | m_t2r) : !(m_latch & !alert_mask), "alert_n", tag);
    check(therm_n, !(m_tl | m_tr), "therm_n", tag);
  endtask

  task automatic model_meas();
    int o, rc, h, rhl, rll, need;
    logic [4:0] c;
    logic any;
    o   = rem_ofs[9] ? int'(rem_ofs) - 1024 : int'(rem_ofs);
    rc  = int'(rem_rd_int) * 4 + int'(rem_rd_frac) + o;
    if (rc < 0) rc = 0;
    if (rc > 1023) rc = 1023;
    h   = int'(trip_hyst);
    rhl = int'(rem_hi_int) * 4 + int'(rem_hi_frac);
    rll = int'(rem_lo_int) * 4 + int'(rem_lo_frac);
    c = {loc_rd > loc_hi_lim, loc_rd <= loc_lo_lim, rc > rhl, rc <= rll, diode_open};
    m_sticky = m_sticky | c;
    m_cond   = c;
    if (loc_rd > loc_trip_lim) m_tl = 1; else if (int'(loc_rd) + h < int'(loc_trip_lim)) m_tl = 0;
    if (rc > 4 * int'(rem_trip_lim)) m_tr = 1; else if (rc + 4 * h < 4 * int'(rem_trip_lim)) m_tr = 0;
    if (loc_rd > loc_hi_lim) m_t2l = 1; else if (int'(loc_rd) + h < int'(loc_hi_lim)) m_t2l = 0;
    if (rc > rhl) m_t2r = 1; else if (rc + 4 * h < rhl) m_t2r = 0;
    any  = |c;
    need = 1 + int'(fault_code[0]) + int'(fault_code[1]) + int'(fault_code[2]);
    if (!any) m_cnt = 0;
    else begin
      if (m_cnt + 1 >= need) begin m_cnt = need; m_latch = 1; end
      else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic meas(input logic [7:0] l, input logic [7:0] ri, input logic [1:0] rf,
                      input logic [9:0] of, input logic op, input string tag);
    @(negedge clk);
    loc_rd = l; rem_rd_int = ri; rem_rd_frac = rf; rem_ofs = of; diode_open = op;
    meas_done = 1;
    check(status_o, exp_status(), "status before capture edge", "R12");
    @(negedge clk);
    meas_done = 0;
    model_meas();
    check_all(tag);
  endtask

  task automatic rd(input string tag);
    @(negedge clk); status_rd = 1;
    @(negedge clk); status_rd = 0;
    m_sticky = m_sticky & m_cond;
    check_all(tag);
  endtask

  task automatic ack(input string tag);
    @(negedge clk); alert_ack = 1;
    @(negedge clk); alert_ack = 0;
    if (m_latch && m_sticky == 0) m_latch = 0;
    check_all(tag);
  endtask

  task automatic clean();
    meas(8'd50, 8'd50, 2'd0, 10'd0, 1'b0, "R7");
    rd("R7");
    ack("R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_all("R1");
    check(status_o, 8'h00, "reset status", "R1");

    loc_hi_lim = 100; loc_lo_lim = 20; loc_trip_lim = 90;
    rem_hi_int = 80; rem_hi_frac = 2; rem_lo_int = 30; rem_lo_frac = 1;
    rem_trip_lim = 95; trip_hyst = 5;
    @(negedge clk);
    check_all("R3");

    // R2 busy mirror
    busy_in = 1; @(negedge clk); m_busy = 1;
    check(status_o[7], 1, "busy bit", "R2");
    busy_in = 0; @(negedge clk); m_busy = 0;
    check(status_o[7], 0, "busy bit", "R2");

    // R4/R8 full local sweep up, then R8 descending through the band
    for (int l = 0; l < 256; l++) begin
      meas(8'(l), 8'd50, 2'd0, 10'd0, 1'b0, "R4");
      rd("R7");
      ack("R10");
    end
    for (int l = 100; l >= 70; l--) meas(8'(l), 8'd50, 2'd0, 10'd0, 1'b0, "R8");
    clean();

    // R5 remote sweep over integer, fraction and offsets
    for (int oi = 0; oi < 4; oi++) begin
      logic [9:0] of;
      case (oi)
        0: of = 10'd0;
        1: of = 10'd5;            // +1.25
        2: of = 10'h3F9;          // -1.75
        default: of = 10'h200;    // -128
      endcase
      for (int ri = 0; ri < 256; ri++)
        for (int rf = 0; rf < 4; rf++) begin
          meas(8'd50, 8'(ri), 2'(rf), of, 1'b0, "R5");
          if (rf == 3) begin rd("R7"); ack("R10"); end
        end
    end
    // clamp at the top end
    meas(8'd50, 8'd255, 2'd3, 10'h1FF, 1'b0, "R5");
    check(status_o[4], 1, "upper clamp high fault", "R5");
    clean();

    // R6 open diode, R7 read while present, then removed
    meas(8'd50, 8'd50, 2'd0, 10'd0, 1'b1, "R6");
    check(status_o[2], 1, "open bit", "R6");
    rd("R7");
    check(status_o[2], 1, "open bit kept while present", "R7");
    meas(8'd50, 8'd50, 2'd0, 10'd0, 1'b0, "R7");
    check(status_o[2], 1, "open bit sticky", "R7");
    rd("R7");
    check(status_o[2], 0, "open bit cleared", "R7");
    ack("R10");

    // R3 limit change without a measurement
    loc_hi_lim = 40;
    repeat (3) @(negedge clk);
    check_all("R3");
    check(status_o[6], 0, "no compare on limit change", "R3");
    meas(8'd50, 8'd50, 2'd0, 10'd0, 1'b0, "R3");
    check(status_o[6], 1, "compare at measurement", "R3");
    loc_hi_lim = 100;
    clean();

    // R9 consecutive fault codes
    for (int k = 1; k <= 4; k++) begin
      fault_code = (k == 1) ? 3'b000 : (k == 2) ? 3'b001 : (k == 3) ? 3'b011 : 3'b111;
      for (int j = 0; j < k - 1; j++) meas(8'd150, 8'd50, 2'd0, 10'd0, 1'b0, "R9");
      meas(8'd50, 8'd50, 2'd0, 10'd0, 1'b0, "R9");
      for (int j = 0; j < k; j++) meas(8'd150, 8'd50, 2'd0, 10'd0, 1'b0, "R9");
      check(alert_n, 0, "alert after required run", "R9");
      clean();
      clean();
    end
    fault_code = 3'b000;

    // R10 mask, ack while set, release
    meas(8'd150, 8'd50, 2'd0, 10'd0, 1'b0, "R10");
    @(negedge clk); alert_mask = 1; @(negedge clk);
    check_all("R10");
    ack("R10");
    @(negedge clk); alert_mask = 0; @(negedge clk);
    check(alert_n, 0, "latch kept through early ack", "R10");
    meas(8'd50, 8'd50, 2'd0, 10'd0, 1'b0, "R10");
    rd("R10");
    ack("R10");
    check(alert_n, 1, "released", "R10");

    // R11 second trip mode with mask set and no ack
    @(negedge clk); pin_mode = 1; alert_mask = 1; @(negedge clk);
    check_all("R11");
    for (int l = 90; l <= 110; l++) meas(8'(l), 8'd50, 2'd0, 10'd0, 1'b0, "R11");
    check(alert_n, 0, "trip2 active", "R11");
    for (int l = 110; l >= 85; l--) meas(8'(l), 8'd50, 2'd0, 10'd0, 1'b0, "R11");
    check(alert_n, 1, "trip2 released without ack", "R11");
    for (int rf = 0; rf < 4; rf++) meas(8'd50, 8'd80, 2'(rf), 10'd0, 1'b0, "R11");
    for (int ri = 80; ri >= 70; ri--) meas(8'd50, 8'(ri), 2'd0, 10'd0, 1'b0, "R11");

    summary();
  end
endmodule